// File: doc/BRIEF.md
# Complementary PWM Triple Up/Down Counter

This block is the counting core of a three-phase complementary PWM generator. Two carrier counters run triangular up/down waves in lockstep. The first runs between the dead-time value and the peak value. The second runs between zero and the half-cycle value, so it always sits one dead time below the first. A third, auxiliary counter runs only inside the two dead-time windows: one around the carrier peak and one around the carrier trough. Duty values for the three phases are compared against the auxiliary counter only while it is active. The three comparator stages drive three complementary output pairs.

Software sets the peak, half-cycle and dead-time values with peak = half + dead, and sets half ≥ 2·dead so that the two windows never overlap. It then raises the start input. A shared clock enable sets the counting rate; every counter advances by at most one step per enabled cycle. All outputs are registered.

Top module: `cpwm_triple_counter`

## Requirements
- R1: While `start` is 0, each clock loads `cnt_a` with `dead_val` and `cnt_b` with 0, sets `dir_a` and `dir_b` to 1 (1 = up, 0 = down) and clears `aux_active`. After reset all counters read 0, all direction flags read 1, and the event flags, the error flag and all PWM outputs read 0.
- R2: With `start` at 1 and `ce` at 1, `cnt_a` steps by one per cycle. Counting up, it reverses to down on the cycle it equals `peak_val`. Counting down, it reverses to up on the cycle it equals `dead_val`.
- R3: `cnt_b` steps in the same cycles as `cnt_a`. Counting up, it reverses on equality with `half_val`. Counting down, it reverses on reaching 0.
- R4: An enabled cycle with `dir_a`=1 and `cnt_a`=`half_val` opens the peak window. The auxiliary counter loads `peak_val`, counts down to `half_val`, then counts up to `peak_val`. After that it clears to 0 and goes inactive.
- R5: An enabled cycle with `dir_b`=0 and `cnt_b`=`dead_val` opens the trough window. The auxiliary counter loads 0, counts up to `dead_val`, then counts down to 0. After that it loads `peak_val` and goes inactive.
- R6: While `aux_active` is 0 and no window opens, `cnt_x` holds its value.
- R7: `peak_pulse` is high for exactly the one cycle after an enabled cycle in which `cnt_a` reverses at `peak_val`. `trough_pulse` behaves the same way for a reversal at `dead_val`.
- R8: `cfg_err` is 1, one cycle later, whenever `peak_val` differs from the untruncated sum `half_val + dead_val`.
- R9: For each phase i, an enabled cycle with `aux_active`=1 and `cnt_x` equal to that phase's duty value sets `pwm_hi[i]`=0 and `pwm_lo[i]`=1 in the peak window, and sets `pwm_hi[i]`=1 and `pwm_lo[i]`=0 in the trough window. Bit 0 is phase U, bit 1 is V and bit 2 is W. The two outputs of a pair are never both 1.
- R10: A cycle with `ce` at 0 and `start` at 1 changes no counter, direction flag or PWM output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Count enable, one step per high cycle |
| start | input | 1 | Run control; 0 holds carriers at their initial values |
| peak_val | input | 16 | Upper turnaround of the first carrier |
| half_val | input | 16 | Upper turnaround of the second carrier |
| dead_val | input | 16 | Dead time, lower turnaround of the first carrier |
| duty_u | input | 16 | Phase U duty compare value |
| duty_v | input | 16 | Phase V duty compare value |
| duty_w | input | 16 | Phase W duty compare value |
| cnt_a | output | 16 | First carrier counter |
| cnt_b | output | 16 | Second carrier counter |
| cnt_x | output | 16 | Auxiliary counter |
| dir_a | output | 1 | First carrier direction, 1 = up |
| dir_b | output | 1 | Second carrier direction, 1 = up |
| dir_x | output | 1 | Auxiliary direction, 1 = up |
| aux_active | output | 1 | Auxiliary counter is inside a window |
| peak_pulse | output | 1 | One-cycle peak turnaround event |
| trough_pulse | output | 1 | One-cycle trough turnaround event |
| cfg_err | output | 1 | Peak, half and dead values are inconsistent |
| pwm_hi | output | 3 | Upper switch drive per phase |
| pwm_lo | output | 3 | Lower switch drive per phase |

## Verification
The counters first run with the enable high on every cycle and a dead time of 3. This shows the exact turnaround cycles and the placement of both windows. The same setup then runs with the enable high one cycle in three, which separates stepping on the enable from stepping on the clock. A stretch with the enable low shows that all counters and outputs freeze. A second configuration with a dead time of 2 uses duty values of 0, 1 and 9. These hit the edges of both windows, so they tell apart compares that land on window entry, at the turning point and at the last active step. A deliberately inconsistent peak value, a stop/restart and a reset during counting complete the run.

// File: rtl/cpwm_pkg.sv
// Shared types for the complementary PWM counter core.
// Assumes nothing beyond the 1-bit encodings below.
package cpwm_pkg;
    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } dir_e;

    typedef enum logic {
        WIN_PEAK   = 1'b0,
        WIN_TROUGH = 1'b1
    } win_e;
endpackage

// File: rtl/cpwm_carrier.sv
// Triangular up/down carrier counter between a low and a high turnaround.
// While run is low it reloads init_val and points up. It steps once per
// enabled cycle and reverses on equality with a turnaround value.
// Assumes lo_val <= init_val <= hi_val when run rises.
module cpwm_carrier
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ce,
    input  logic [W-1:0] lo_val,
    input  logic [W-1:0] hi_val,
    input  logic [W-1:0] init_val,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         turn_hi,
    output logic         turn_lo
);
    localparam logic [W-1:0] ONE = W'(1);

    // Reversal indicators for the current enabled cycle.
    always_comb begin
        turn_hi = run && ce && (dir == DIR_UP) && (cnt == hi_val);
        turn_lo = run && ce && (dir == DIR_DN) && (cnt == lo_val);
    end

    // Count register with reload, step and turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (!run) begin
            cnt <= init_val;
            dir <= DIR_UP;
        end else if (ce) begin
            if (turn_hi) begin
                dir <= DIR_DN;
                cnt <= cnt - ONE;
            end else if (turn_lo) begin
                dir <= DIR_UP;
                cnt <= cnt + ONE;
            end else if (dir == DIR_UP) begin
                cnt <= cnt + ONE;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // Each enabled running cycle moves the count by exactly one.
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ce) |=> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

    // Idle cycles reload the initial value pointing up.
    assert_idle_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((cnt == $past(init_val)) && (dir == DIR_UP)));

    // No enable, no movement.
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ce) |=> ($stable(cnt) && $stable(dir)));
endmodule

// File: rtl/cpwm_aux.sv
// Auxiliary counter that runs only inside the dead-time windows.
// Peak window: load peak, count down to half, up to peak, then clear and stop.
// Trough window: load 0, count up to dead, down to 0, then load peak and stop.
// Outside a window the value is held. A window entry wins over a running window.
// Assumes the caller raises each entry strobe for a single enabled cycle.
module cpwm_aux
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ce,
    input  logic         enter_pk,
    input  logic         enter_tr,
    input  logic [W-1:0] peak_val,
    input  logic [W-1:0] half_val,
    input  logic [W-1:0] dead_val,
    output logic [W-1:0] x,
    output dir_e         dir,
    output logic         active,
    output win_e         win
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;

    // An auxiliary step happens only when running and enabled.
    always_comb step = run && ce;

    // Window state machine and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x      <= '0;
            dir    <= DIR_UP;
            active <= 1'b0;
            win    <= WIN_PEAK;
        end else if (!run) begin
            active <= 1'b0;
        end else if (step) begin
            if (enter_pk) begin
                x      <= peak_val;
                dir    <= DIR_DN;
                active <= 1'b1;
                win    <= WIN_PEAK;
            end else if (enter_tr) begin
                x      <= '0;
                dir    <= DIR_UP;
                active <= 1'b1;
                win    <= WIN_TROUGH;
            end else if (active) begin
                if (win == WIN_PEAK) begin
                    if (dir == DIR_DN) begin
                        if (x == half_val) begin
                            dir <= DIR_UP;
                            x   <= x + ONE;
                        end else begin
                            x <= x - ONE;
                        end
                    end else if (x == peak_val) begin
                        x      <= '0;
                        active <= 1'b0;
                    end else begin
                        x <= x + ONE;
                    end
                end else begin
                    if (dir == DIR_UP) begin
                        if (x == dead_val) begin
                            dir <= DIR_DN;
                            x   <= x - ONE;
                        end else begin
                            x <= x + ONE;
                        end
                    end else if (x == '0) begin
                        x      <= peak_val;
                        active <= 1'b0;
                    end else begin
                        x <= x - ONE;
                    end
                end
            end
        end
    end

    // Held value while outside any window.
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(step && (enter_pk || enter_tr))) |=> $stable(x));

    // A peak entry always lands on the peak value, counting down.
    assert_peak_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && enter_pk) |=> (active && (x == $past(peak_val)) && (dir == DIR_DN)));

    // A trough entry always starts from zero, counting up.
    assert_trough_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !enter_pk && enter_tr) |=> (active && (x == '0) && (dir == DIR_UP)));
endmodule

// File: rtl/cpwm_phase.sv
// One complementary output pair driven by a duty compare against the
// auxiliary counter. A match in the peak window turns the upper switch off
// and the lower on; a match in the trough window does the reverse. Both are
// off after reset. Compares happen only on enabled cycles inside a window.
module cpwm_phase
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         active,
    input  win_e         win,
    input  logic [W-1:0] x,
    input  logic [W-1:0] duty,
    output logic         hi,
    output logic         lo
);
    logic hit;

    // Duty match qualified by the window being open.
    always_comb hit = ce && active && (x == duty);

    // Output pair update on a qualified match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= 1'b0;
            lo <= 1'b0;
        end else if (hit) begin
            hi <= (win == WIN_TROUGH);
            lo <= (win == WIN_PEAK);
        end
    end

    // Never both switches of a pair on.
    assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

    // Outputs move only through a window compare.
    assert_pair_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(hi) && $stable(lo)));
endmodule

// File: rtl/cpwm_triple_counter.sv
// Counter core of a three-phase complementary PWM generator.
// Carrier A runs dead..peak, carrier B runs 0..half in lockstep, and the
// auxiliary counter runs only in the dead-time windows at peak and trough.
// Three compare stages drive complementary output pairs.
// Assumes peak == half + dead (flagged otherwise) and half >= 2*dead.
module cpwm_triple_counter
    import cpwm_pkg::*;
#(
    parameter int W      = 16,
    parameter int PHASES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              start,
    input  logic [W-1:0]      peak_val,
    input  logic [W-1:0]      half_val,
    input  logic [W-1:0]      dead_val,
    input  logic [W-1:0]      duty_u,
    input  logic [W-1:0]      duty_v,
    input  logic [W-1:0]      duty_w,
    output logic [W-1:0]      cnt_a,
    output logic [W-1:0]      cnt_b,
    output logic [W-1:0]      cnt_x,
    output logic              dir_a,
    output logic              dir_b,
    output logic              dir_x,
    output logic              aux_active,
    output logic              peak_pulse,
    output logic              trough_pulse,
    output logic              cfg_err,
    output logic [PHASES-1:0] pwm_hi,
    output logic [PHASES-1:0] pwm_lo
);
    localparam int SW = W + 1;

    dir_e         a_dir, b_dir, x_dir;
    win_e         x_win;
    logic         a_hi, a_lo, b_hi_unused, b_lo_unused;
    logic         enter_pk, enter_tr;
    logic [W-1:0] duty_arr [PHASES];

    // Carrier A: dead..peak, starts from dead.
    cpwm_carrier #(.W(W)) u_car_a (
        .clk(clk), .rst_n(rst_n), .run(start), .ce(ce),
        .lo_val(dead_val), .hi_val(peak_val), .init_val(dead_val),
        .cnt(cnt_a), .dir(a_dir), .turn_hi(a_hi), .turn_lo(a_lo)
    );

    // Carrier B: 0..half, starts from zero.
    cpwm_carrier #(.W(W)) u_car_b (
        .clk(clk), .rst_n(rst_n), .run(start), .ce(ce),
        .lo_val('0), .hi_val(half_val), .init_val('0),
        .cnt(cnt_b), .dir(b_dir), .turn_hi(b_hi_unused), .turn_lo(b_lo_unused)
    );

    // Window entry strobes from the carriers crossing their inner thresholds.
    always_comb begin
        enter_pk = (a_dir == DIR_UP) && (cnt_a == half_val);
        enter_tr = (b_dir == DIR_DN) && (cnt_b == dead_val);
    end

    // Auxiliary dead-time counter.
    cpwm_aux #(.W(W)) u_aux (
        .clk(clk), .rst_n(rst_n), .run(start), .ce(ce),
        .enter_pk(enter_pk), .enter_tr(enter_tr),
        .peak_val(peak_val), .half_val(half_val), .dead_val(dead_val),
        .x(cnt_x), .dir(x_dir), .active(aux_active), .win(x_win)
    );

    // Direction flags as plain bits.
    always_comb begin
        dir_a = (a_dir == DIR_UP);
        dir_b = (b_dir == DIR_UP);
        dir_x = (x_dir == DIR_UP);
    end

    // Duty values gathered per phase.
    always_comb begin
        for (int i = 0; i < PHASES; i++) duty_arr[i] = '0;
        duty_arr[0] = duty_u;
        if (PHASES > 1) duty_arr[1] = duty_v;
        if (PHASES > 2) duty_arr[2] = duty_w;
    end

    // One compare stage per phase.
    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        cpwm_phase #(.W(W)) u_ph (
            .clk(clk), .rst_n(rst_n), .ce(ce), .active(aux_active),
            .win(x_win), .x(cnt_x), .duty(duty_arr[g]),
            .hi(pwm_hi[g]), .lo(pwm_lo[g])
        );
    end

    // Turnaround events and configuration check, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_pulse   <= 1'b0;
            trough_pulse <= 1'b0;
            cfg_err      <= 1'b0;
        end else begin
            peak_pulse   <= a_hi;
            trough_pulse <= a_lo;
            cfg_err      <= (SW'(peak_val) != (SW'(half_val) + SW'(dead_val)));
        end
    end

    // A peak event coincides with carrier A having turned down.
    assert_peak_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        peak_pulse |-> !dir_a);

    // A trough event coincides with carrier A having turned up.
    assert_trough_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trough_pulse |-> dir_a);

    // Events last one cycle.
    assert_peak_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        peak_pulse |=> !peak_pulse);

    // Carrier B moves in the same cycles as carrier A.
    assert_lockstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ce) |=> (cnt_b != $past(cnt_b)));
endmodule

// File: tb/sim_cpwm_triple_counter.sv
// Behavioural reference model compared with the design on every clock.
module sim_cpwm_triple_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        start = 1'b0;
    logic [15:0] peak_val = 16'd13, half_val = 16'd10, dead_val = 16'd3;
    logic [15:0] duty_u = 16'd11, duty_v = 16'd2, duty_w = 16'd20;
    logic [15:0] cnt_a, cnt_b, cnt_x;
    logic        dir_a, dir_b, dir_x, aux_active, peak_pulse, trough_pulse, cfg_err;
    logic [2:0]  pwm_hi, pwm_lo;

    int vectors = 0;
    int fails = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cpwm_triple_counter u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .start(start),
        .peak_val(peak_val), .half_val(half_val), .dead_val(dead_val),
        .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_x(cnt_x),
        .dir_a(dir_a), .dir_b(dir_b), .dir_x(dir_x),
        .aux_active(aux_active), .peak_pulse(peak_pulse),
        .trough_pulse(trough_pulse), .cfg_err(cfg_err),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    // Reference state
    int ma, mb, mx, mda, mdb, mdx, mact, mpeakwin, mpe, mte, merr;
    int mhi[3], mlo[3];

    always @(posedge clk) begin
        int pk, hf, dd, na, nb, nx, nda, ndb, ndx, nact, nwin;
        int dut[3];
        bit go_pk, go_tr;
        pk = peak_val; hf = half_val; dd = dead_val;
        dut[0] = duty_u; dut[1] = duty_v; dut[2] = duty_w;
        if (!rst_n) begin
            ma = 0; mb = 0; mx = 0; mda = 1; mdb = 1; mdx = 1; mact = 0;
            mpeakwin = 1; mpe = 0; mte = 0; merr = 0;
            for (int i = 0; i < 3; i++) begin mhi[i] = 0; mlo[i] = 0; end
            cmp_on = 1;
        end else begin
            na = ma; nb = mb; nx = mx; nda = mda; ndb = mdb; ndx = mdx;
            nact = mact; nwin = mpeakwin;
            mpe = 0; mte = 0;
            if (ce) begin
                for (int i = 0; i < 3; i++)
                    if (mact == 1 && mx == dut[i]) begin
                        mhi[i] = mpeakwin ? 0 : 1;
                        mlo[i] = mpeakwin ? 1 : 0;
                    end
            end
            if (!start) begin
                na = dd; nda = 1; nb = 0; ndb = 1; nact = 0;
            end else if (ce) begin
                go_pk = (mda == 1 && ma == hf);
                go_tr = (mdb == 0 && mb == dd);
                if (mda == 1 && ma == pk) begin nda = 0; na = ma - 1; mpe = 1; end
                else if (mda == 0 && ma == dd) begin nda = 1; na = ma + 1; mte = 1; end
                else na = mda ? ma + 1 : ma - 1;
                if (mdb == 1 && mb == hf) begin ndb = 0; nb = mb - 1; end
                else if (mdb == 0 && mb == 0) begin ndb = 1; nb = mb + 1; end
                else nb = mdb ? mb + 1 : mb - 1;
                if (go_pk) begin nx = pk; ndx = 0; nact = 1; nwin = 1; end
                else if (go_tr) begin nx = 0; ndx = 1; nact = 1; nwin = 0; end
                else if (mact == 1) begin
                    if (mpeakwin == 1) begin
                        if (mdx == 0) begin
                            if (mx == hf) begin ndx = 1; nx = mx + 1; end else nx = mx - 1;
                        end else if (mx == pk) begin nx = 0; nact = 0; end
                        else nx = mx + 1;
                    end else begin
                        if (mdx == 1) begin
                            if (mx == dd) begin ndx = 0; nx = mx - 1; end else nx = mx + 1;
                        end else if (mx == 0) begin nx = pk; nact = 0; end
                        else nx = mx - 1;
                    end
                end
            end
            ma = na & 16'hFFFF; mb = nb & 16'hFFFF; mx = nx & 16'hFFFF;
            mda = nda; mdb = ndb; mdx = ndx; mact = nact; mpeakwin = nwin;
            merr = (pk != hf + dd) ? 1 : 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 cnt_a (R1 when idle)", cnt_a, ma);
            chk("R2 dir_a", dir_a, mda);
            chk("R3 cnt_b", cnt_b, mb);
            chk("R3 dir_b", dir_b, mdb);
            chk("R4/R5/R6 cnt_x", cnt_x, mx);
            chk("R4/R5 dir_x", dir_x, mdx);
            chk("R6 aux_active", aux_active, mact);
            chk("R7 peak_pulse", peak_pulse, mpe);
            chk("R7 trough_pulse", trough_pulse, mte);
            chk("R8 cfg_err", cfg_err, merr);
            for (int i = 0; i < 3; i++) begin
                chk("R9 pwm_hi", pwm_hi[i], mhi[i]);
                chk("R9 pwm_lo", pwm_lo[i], mlo[i]);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] sa, sb, sx;
        logic [2:0]  sh, sl;
        cycles(3);
        // R1: reset state
        chk("R1 reset cnt_a", cnt_a, 0);
        chk("R1 reset dir_a", dir_a, 1);
        chk("R1 reset pwm_hi", pwm_hi, 0);
        rst_n = 1'b1; ce = 1'b1;
        cycles(5);
        chk("R1 idle cnt_a = dead", cnt_a, 3);
        chk("R1 idle cnt_b = 0", cnt_b, 0);
        start = 1'b1;
        cycles(60);
        // sparse enable
        for (int i = 0; i < 60; i++) begin
            ce = (i % 3 == 0);
            cycles(1);
        end
        // R10: enable held low freezes everything
        ce = 1'b0;
        cycles(1);
        sa = cnt_a; sb = cnt_b; sx = cnt_x; sh = pwm_hi; sl = pwm_lo;
        cycles(10);
        chk("R10 cnt_a frozen", cnt_a, sa);
        chk("R10 cnt_b frozen", cnt_b, sb);
        chk("R10 cnt_x frozen", cnt_x, sx);
        chk("R10 pwm_hi frozen", pwm_hi, sh);
        chk("R10 pwm_lo frozen", pwm_lo, sl);
        // second configuration with edge duty values
        ce = 1'b1; start = 1'b0;
        dead_val = 16'd2; half_val = 16'd8; peak_val = 16'd10;
        duty_u = 16'd9; duty_v = 16'd0; duty_w = 16'd1;
        cycles(4);
        start = 1'b1;
        cycles(80);
        // R8: inconsistent peak
        peak_val = 16'd11;
        cycles(2);
        chk("R8 cfg_err raised", cfg_err, 1);
        cycles(3);
        peak_val = 16'd10; start = 1'b0;
        cycles(3);
        chk("R8 cfg_err cleared", cfg_err, 0);
        start = 1'b1;
        cycles(30);
        // reset while counting
        rst_n = 1'b0;
        cycles(2);
        chk("R1 reset mid-run cnt_x", cnt_x, 0);
        rst_n = 1'b1;
        cycles(40);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule